// File: doc/BRIEF.md
# Transceiver State-Change Sequencer

This block moves an external radio transceiver into a requested operating state. A host hands it a 5-bit state command; the sequencer then polls the radio's status register, writes the command register when needed, waits the settling time the transition calls for, and reads the status back to confirm the outcome. All register traffic passes through a single-outstanding byte-transaction port that an SPI master serves with a request/acknowledge handshake.

The sequencer tolerates a radio that is still mid-transition by re-polling after a microsecond. It maps the two forced commands to the states they end in. It also handles the radio slipping on its own into a busy receive-with-acknowledge state. When the command was the listen-with-acknowledge state, it counts that outcome as success. When the command was a plain transmit-ready, it escalates to the forced transmit-ready command. Completion is a single `done_o` pulse; an unresolved mismatch raises `warn_o` in the same cycle, together with the from-state, the expected state and the observed state. Microsecond waits use a clock-cycles-per-microsecond prescaler.

Top module: `trx_state_seq`

## Requirements
- R1: After a request is accepted, the block reads the status register at `STATUS_ADDR` (default 0x01) and uses bits [4:0] of the read data; a value of 0x1F means a transition is in progress, and the block then waits one microsecond (`CYC_PER_US` idle cycles) and reads the status register again.
- R2: If the status equals the requested command code, the block completes with `done_o` and without `warn_o`, and it issues no write.
- R3: Otherwise the block writes the command code, zero-extended to the data width, to `CMD_ADDR` (default 0x02). It then waits one microsecond and reads the status register to verify.
- R4: Command 0x03 (forced off) is verified against state 0x08, and command 0x04 (forced transmit-ready) against state 0x09; every other command is verified against its own code.
- R5: When the status read before the write was 0x11 (busy receive with acknowledge) and the command is the non-forced transmit-ready 0x09, the verify wait is `FRAME_US + ACK_US` microseconds (default 4096 + 545) instead of one.
- R6: A verify readback of 0x11 when the expected state is 0x16 (listen with acknowledge) completes without a warning.
- R7: A verify readback of 0x11 after the non-forced command 0x09 restarts the whole sequence with command 0x04 and produces a single completion at its end. After a forced 0x04, the same readback is an ordinary mismatch.
- R8: Any other verify mismatch completes with `warn_o` high together with `done_o`. In that cycle, `warn_from_o` holds the status seen before the write, `warn_target_o` the expected state and `warn_actual_o` the readback.
- R9: A request is taken only when `req_ready_o` is high. A request presented while the block is busy, including during the completion cycle, has no effect.
- R10: A bus request, together with its address, write flag and write data, stays asserted and unchanged until `bus_ack_i` is seen.
- R11: Out of reset, `req_ready_o` is high and `bus_req_o`, `done_o` and `warn_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | State-change request |
| req_state_i | input | 5 | Requested command code |
| req_ready_o | output | 1 | Idle, request accepted this cycle |
| done_o | output | 1 | One-cycle completion pulse |
| warn_o | output | 1 | Completion with unresolved mismatch |
| warn_from_o | output | 5 | State before the command write |
| warn_target_o | output | 5 | Expected final state |
| warn_actual_o | output | 5 | State read at verification |
| bus_req_o | output | 1 | Register transaction request |
| bus_write_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | ADDR_W | Register address |
| bus_wdata_o | output | DATA_W | Write data |
| bus_ack_i | input | 1 | Transaction complete; read data valid |
| bus_rdata_i | input | DATA_W | Read data |

## Verification
Two events can coincide here: the completion pulse and a new request from the host. The bench holds a request with a different command high through the whole busy period, including the edge that ends the completion cycle. It then expects no further bus traffic and the idle flag afterwards. A second coincidence is the verify readback landing on the busy-receive state, where completion and restart compete. The bench provokes it with scripted status sequences and judges the outcome from the exact transaction list and the inter-acknowledge spacing that its behavioural model predicts.

// File: rtl/trx_seq_pkg.sv
package trx_seq_pkg;
  localparam int unsigned STATE_W = 5;

  localparam logic [STATE_W-1:0] ST_IN_TRANSIT   = 5'h1F;
  localparam logic [STATE_W-1:0] ST_RX_BUSY_ACK  = 5'h11;
  localparam logic [STATE_W-1:0] ST_RX_LISTEN_ACK = 5'h16;
  localparam logic [STATE_W-1:0] ST_OFF          = 5'h08;
  localparam logic [STATE_W-1:0] ST_TX_READY     = 5'h09;
  localparam logic [STATE_W-1:0] CMD_FORCE_OFF   = 5'h03;
  localparam logic [STATE_W-1:0] CMD_FORCE_TX    = 5'h04;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_CUR,
    S_WAIT_RETRY,
    S_WR_CMD,
    S_WAIT_SETTLE,
    S_RD_CHK,
    S_FIN
  } seq_state_e;
endpackage

// File: rtl/seq_target_map.sv
module seq_target_map
  import trx_seq_pkg::*;
(
  input  logic [STATE_W-1:0] cmd_i,
  output logic [STATE_W-1:0] expect_o,
  output logic               forced_o
);
  always_comb begin
    forced_o = 1'b0;
    expect_o = cmd_i;
    unique case (cmd_i)
      CMD_FORCE_OFF: begin expect_o = ST_OFF;      forced_o = 1'b1; end
      CMD_FORCE_TX:  begin expect_o = ST_TX_READY; forced_o = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/seq_us_timer.sv
module seq_us_timer #(
  parameter int unsigned CYC_PER_US = 4,
  parameter int unsigned MAX_US     = 4641,
  parameter int unsigned US_W       = $clog2(MAX_US + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [US_W-1:0] us_i,
  output logic            expire_o
);
  localparam int unsigned MAX_CYC = CYC_PER_US * MAX_US;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic [CNT_W-1:0] load_cyc;

  assign load_cyc = CNT_W'(32'(us_i) * CYC_PER_US - 32'd1);
  assign expire_o = busy_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= load_cyc;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  AST_WAIT_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> us_i != '0); // R3
  AST_EXPIRE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o && !start_i |=> !expire_o); // R5
endmodule

// File: rtl/trx_state_seq.sv
module trx_state_seq
  import trx_seq_pkg::*;
#(
  parameter int unsigned CYC_PER_US = 4,
  parameter int unsigned SHORT_US   = 1,
  parameter int unsigned FRAME_US   = 4096,
  parameter int unsigned ACK_US     = 545,
  parameter int unsigned ADDR_W     = 6,
  parameter int unsigned DATA_W     = 8,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 'h01,
  parameter logic [ADDR_W-1:0] CMD_ADDR    = 'h02
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [4:0]        req_state_i,
  output logic              req_ready_o,
  output logic              done_o,
  output logic              warn_o,
  output logic [4:0]        warn_from_o,
  output logic [4:0]        warn_target_o,
  output logic [4:0]        warn_actual_o,
  output logic              bus_req_o,
  output logic              bus_write_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic              bus_ack_i,
  input  logic [DATA_W-1:0] bus_rdata_i
);
  localparam int unsigned LONG_US = FRAME_US + ACK_US;
  localparam int unsigned MAX_US  = (LONG_US > SHORT_US) ? LONG_US : SHORT_US;
  localparam int unsigned US_W    = $clog2(MAX_US + 1);

  seq_state_e         state_q;
  logic [STATE_W-1:0] cmd_q, from_q, actual_q;
  logic               warn_q;
  logic [STATE_W-1:0] rd_state, exp_state;
  logic               forced;
  logic               tmr_start, tmr_expire;
  logic [US_W-1:0]    tmr_us;
  logic               unused_rdata_hi;

  assign rd_state        = bus_rdata_i[STATE_W-1:0];
  assign unused_rdata_hi = ^bus_rdata_i[DATA_W-1:STATE_W];

  seq_target_map u_map (
    .cmd_i    (cmd_q),
    .expect_o (exp_state),
    .forced_o (forced)
  );

  // long settle only when leaving busy-receive towards a plain transmit-ready
  assign tmr_start = bus_ack_i &&
                     ((state_q == S_WR_CMD) ||
                      (state_q == S_RD_CUR && rd_state == ST_IN_TRANSIT));
  assign tmr_us = (state_q == S_WR_CMD && from_q == ST_RX_BUSY_ACK &&
                   exp_state == ST_TX_READY && !forced) ? US_W'(LONG_US) : US_W'(SHORT_US);

  seq_us_timer #(
    .CYC_PER_US (CYC_PER_US),
    .MAX_US     (MAX_US),
    .US_W       (US_W)
  ) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (tmr_start),
    .us_i     (tmr_us),
    .expire_o (tmr_expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      cmd_q    <= '0;
      from_q   <= '0;
      actual_q <= '0;
      warn_q   <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (req_valid_i) begin
          cmd_q   <= req_state_i;
          warn_q  <= 1'b0;
          state_q <= S_RD_CUR;
        end
        S_RD_CUR: if (bus_ack_i) begin
          if (rd_state == ST_IN_TRANSIT) state_q <= S_WAIT_RETRY;
          else if (rd_state == cmd_q)    state_q <= S_FIN;
          else begin
            from_q  <= rd_state;
            state_q <= S_WR_CMD;
          end
        end
        S_WAIT_RETRY:  if (tmr_expire) state_q <= S_RD_CUR;
        S_WR_CMD:      if (bus_ack_i)  state_q <= S_WAIT_SETTLE;
        S_WAIT_SETTLE: if (tmr_expire) state_q <= S_RD_CHK;
        S_RD_CHK: if (bus_ack_i) begin
          actual_q <= rd_state;
          if (rd_state == exp_state) state_q <= S_FIN;
          else if (rd_state == ST_RX_BUSY_ACK && exp_state == ST_RX_LISTEN_ACK)
            state_q <= S_FIN;
          else if (rd_state == ST_RX_BUSY_ACK && exp_state == ST_TX_READY && !forced) begin
            cmd_q   <= CMD_FORCE_TX;
            state_q <= S_RD_CUR;
          end else begin
            warn_q  <= 1'b1;
            state_q <= S_FIN;
          end
        end
        S_FIN:   state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready_o   = (state_q == S_IDLE);
  assign done_o        = (state_q == S_FIN);
  assign warn_o        = done_o && warn_q;
  assign warn_from_o   = from_q;
  assign warn_target_o = exp_state;
  assign warn_actual_o = actual_q;

  assign bus_req_o   = (state_q == S_RD_CUR) || (state_q == S_WR_CMD) || (state_q == S_RD_CHK);
  assign bus_write_o = (state_q == S_WR_CMD);
  assign bus_addr_o  = bus_write_o ? CMD_ADDR : STATUS_ADDR;
  assign bus_wdata_o = DATA_W'(cmd_q);

  AST_ACCEPT_READS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> bus_req_o && !bus_write_o); // R1
  AST_DONE_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(bus_req_o && !bus_write_o && bus_ack_i)); // R2
  AST_WARN_MISMATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warn_o |-> warn_actual_o != warn_target_o); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !bus_req_o && !done_o); // R9
  AST_BUS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_addr_o) &&
                                $stable(bus_write_o) && $stable(bus_wdata_o)); // R10
endmodule

// File: tb/tb_trx_state_seq.sv
module tb_trx_state_seq;
  localparam int TB_CPU  = 2;
  localparam int TB_LONG = 4096 + 545;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [4:0] req_state = '0;
  logic       req_ready, done, warn;
  logic [4:0] w_from, w_tgt, w_act;
  logic       bus_req, bus_write, bus_ack;
  logic [5:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;

  always #5 clk = ~clk;

  trx_state_seq #(.CYC_PER_US(TB_CPU)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_state_i(req_state), .req_ready_o(req_ready),
    .done_o(done), .warn_o(warn),
    .warn_from_o(w_from), .warn_target_o(w_tgt), .warn_actual_o(w_act),
    .bus_req_o(bus_req), .bus_write_o(bus_write), .bus_addr_o(bus_addr),
    .bus_wdata_o(bus_wdata), .bus_ack_i(bus_ack), .bus_rdata_i(bus_rdata)
  );

  int n_chk = 0, n_err = 0, cyc = 0;
  logic [4:0] stat_q[$];
  bit exp_wr[$]; int exp_dat[$]; int exp_gap[$];
  bit act_wr[$]; int act_dat[$]; int act_cyc[$];
  bit exp_warn; int exp_from, exp_tgt, exp_act;
  bit done_seen; int done_cyc; bit d_warn; int d_from, d_tgt, d_act;
  bit inject = 0, drop_pend = 0;
  bit pend = 0; logic [5:0] pend_a; logic pend_w; logic [7:0] pend_d;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // radio model and output monitor, both at the falling edge
  initial begin
    bus_ack = 1'b0; bus_rdata = '0;
    forever begin
      @(negedge clk);
      if (done) begin
        done_seen = 1; done_cyc = cyc; d_warn = warn;
        d_from = w_from; d_tgt = w_tgt; d_act = w_act;
      end
      if (inject) begin
        if (drop_pend) begin req_valid = 1'b0; inject = 0; drop_pend = 0; end
        else begin req_valid = 1'b1; req_state = 5'h08; if (done) drop_pend = 1; end
      end
      if (bus_ack) begin
        bus_ack = 1'b0;
        if (bus_req) begin pend = 1; pend_a = bus_addr; pend_w = bus_write; pend_d = bus_wdata; end
      end else if (bus_req) begin
        if (pend)
          chk(pend_a == bus_addr && pend_w == bus_write && pend_d == bus_wdata,
              "R10 request held until ack", int'({bus_write, bus_addr, bus_wdata}),
              int'({pend_w, pend_a, pend_d}));
        pend = 0;
        bus_ack = 1'b1;
        act_wr.push_back(bus_write);
        act_cyc.push_back(cyc);
        if (bus_write) begin
          act_dat.push_back(int'(bus_wdata));
          chk(bus_addr == 6'h02, "R3 write address", int'(bus_addr), 2);
        end else begin
          act_dat.push_back(0);
          bus_rdata = {3'b101, (stat_q.size() > 0) ? stat_q.pop_front() : 5'h00};
          chk(bus_addr == 6'h01, "R1 read address", int'(bus_addr), 1);
        end
      end
    end
  end

  // behavioural prediction of bus traffic and result
  task automatic model(input logic [4:0] cmd);
    logic [4:0] sc[$];
    logic [4:0] cur, s, a, e;
    int gap, d;
    sc = stat_q; cur = cmd; gap = -1; exp_warn = 0;
    exp_wr.delete(); exp_dat.delete(); exp_gap.delete();
    forever begin
      s = sc.pop_front();
      exp_wr.push_back(0); exp_dat.push_back(0); exp_gap.push_back(gap);
      if (s == 5'h1F) begin gap = TB_CPU + 1; continue; end
      if (s == cur) break;
      exp_wr.push_back(1); exp_dat.push_back(int'(cur)); exp_gap.push_back(2);
      e = (cur == 5'h03) ? 5'h08 : (cur == 5'h04) ? 5'h09 : cur;
      d = (s == 5'h11 && cur == 5'h09) ? TB_LONG : 1;
      a = sc.pop_front();
      exp_wr.push_back(0); exp_dat.push_back(0); exp_gap.push_back(d * TB_CPU + 1);
      if (a == e) break;
      if (a == 5'h11 && e == 5'h16) break;
      if (a == 5'h11 && cur == 5'h09) begin cur = 5'h04; gap = 2; continue; end
      exp_warn = 1; exp_from = s; exp_tgt = e; exp_act = a;
      break;
    end
  endtask

  task automatic run_case(input logic [4:0] cmd, input bit inj, input string tag);
    int to;
    model(cmd);
    act_wr.delete(); act_dat.delete(); act_cyc.delete();
    done_seen = 0;
    @(negedge clk);
    req_valid = 1'b1; req_state = cmd;
    @(negedge clk);
    req_valid = 1'b0;
    if (inj) inject = 1;
    to = 0;
    while (!done_seen && to < 40000) begin @(negedge clk); to++; end
    chk(done_seen, {tag, " completion"}, int'(done_seen), 1);
    repeat (4) @(negedge clk);
    chk(!bus_req && req_ready, {tag, " idle after done R9"}, int'({bus_req, req_ready}), 1);
    chk(act_wr.size() == exp_wr.size(), {tag, " transaction count"}, act_wr.size(), exp_wr.size());
    if (act_wr.size() == exp_wr.size()) begin
      for (int i = 0; i < exp_wr.size(); i++) begin
        chk(act_wr[i] == exp_wr[i] && act_dat[i] == exp_dat[i], {tag, " transaction kind/data"},
            act_dat[i] + (act_wr[i] ? 256 : 0), exp_dat[i] + (exp_wr[i] ? 256 : 0));
        if (exp_gap[i] >= 0)
          chk(act_cyc[i] - act_cyc[i-1] == exp_gap[i], {tag, " spacing"},
              act_cyc[i] - act_cyc[i-1], exp_gap[i]);
      end
      if (done_seen)
        chk(done_cyc - act_cyc[act_cyc.size()-1] == 1, {tag, " done timing"},
            done_cyc - act_cyc[act_cyc.size()-1], 1);
    end
    chk(d_warn == exp_warn, {tag, " warn flag"}, int'(d_warn), int'(exp_warn));
    if (exp_warn && d_warn)
      chk(d_from == exp_from && d_tgt == exp_tgt && d_act == exp_act, {tag, " warn fields R8"},
          (d_from << 10) | (d_tgt << 5) | d_act, (exp_from << 10) | (exp_tgt << 5) | exp_act);
    stat_q.delete();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && !bus_req && !done && !warn, "R11 reset state",
        int'({req_ready, bus_req, done, warn}), 8);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !bus_req && !done && !warn, "R11 after release",
        int'({req_ready, bus_req, done, warn}), 8);

    stat_q = '{5'h1F, 5'h1F, 5'h08};        run_case(5'h08, 0, "R1 R2 retry then match");
    stat_q = '{5'h08, 5'h06};               run_case(5'h06, 0, "R3 plain change");
    stat_q = '{5'h09, 5'h08};               run_case(5'h03, 0, "R4 forced off");
    stat_q = '{5'h16, 5'h09};               run_case(5'h04, 0, "R4 forced tx");
    stat_q = '{5'h11, 5'h09};               run_case(5'h09, 0, "R5 long settle");
    stat_q = '{5'h11, 5'h09};               run_case(5'h04, 0, "R5 forced short settle");
    stat_q = '{5'h08, 5'h11};               run_case(5'h16, 0, "R6 busy accepted");
    stat_q = '{5'h08, 5'h11, 5'h11, 5'h09}; run_case(5'h09, 0, "R7 escalation");
    stat_q = '{5'h08, 5'h11};               run_case(5'h04, 0, "R7 forced no loop");
    stat_q = '{5'h08, 5'h09};               run_case(5'h06, 0, "R8 mismatch");
    stat_q = '{5'h1F, 5'h08, 5'h1F};        run_case(5'h16, 0, "R8 transit at verify");
    stat_q = '{5'h08, 5'h06};               run_case(5'h06, 1, "R9 request while busy");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule